// File: doc/BRIEF.md
# Parallel Phase-Domain Frequency Offset Tracker

This block tracks and removes a carrier frequency offset from a stream of QPSK symbols that arrive already in polar form, one sample per symbol, with eight symbol phases presented side by side in each clock. It works only on phase angles. Each phase is an unsigned fraction of a full turn, so all phase arithmetic wraps modulo one turn. No multiplier is used anywhere in the datapath.

The block is a feedback loop. A phase ramp built from the current frequency estimate is subtracted from every incoming symbol, and the rotated phases go out one clock later. Then, for each lane, the block takes the phase step from the symbol before it. Lane 0 uses the last lane of the previous block. It removes the QPSK modulation from that step by a pre-decision: multiplying by four modulo a turn. The eight residuals are summed, scaled by a programmable right shift and added to a saturating frequency accumulator. The accumulator can be read on a port.

Because the modulation is removed by the fourfold multiply, the loop captures residual offsets up to one eighth of a turn per symbol. That is one eighth of the symbol rate.

Top module: `phase_freq_tracker`

## Requirements
- R1: While reset is held low and on the first cycle after it, `outValid` is 0, `freqEst` is 0 and every output phase is 0.
- R2: A block accepted with `inValid` high appears on the outputs one clock later, with `outValid` high. Lane k's input phase sits at bits [10k+9:10k] of `inPh`. Its output, at the same bits of `outPh`, is (input − rotation) mod 1024. The rotation is bits [19:10] of (base + k·freq) mod 2^20.
- R3: `freqEst` is a signed 18-bit value in units of 1/1024 phase step per symbol. The 20-bit base register starts at 0 and advances by 8·freq, mod 2^20, only on a clock that accepts a block. The freq used is the value held in that clock.
- R4: In the clock after a block is output, a per-lane error is formed. The step d = (phase_k − phase_prev) mod 1024 is taken, where phase_prev is output lane k−1, or for lane 0 the output lane 7 of the previous output block. The value 4·d mod 1024 is then read as a signed 10-bit number.
- R5: For the first output block after reset, the lane-0 error is forced to 0, because no earlier block exists.
- R6: On each clock with `outValid` high, `freqEst` becomes freqEst + ((sum of the eight errors) · 1024) arithmetically shifted right by `gainShift`.
- R7: The update saturates at +131071 and at −131072 rather than wrapping.
- R8: On a clock with `inValid` low, the output phases and the base hold. When `outValid` is low, `freqEst` holds.
- R9: With a constant offset of up to about 100 phase steps per symbol (out of 1024) and `gainShift` of 6 or 7, `freqEst`/1024 settles within 3 of the true offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A block of eight phases is present |
| inPh | input | 80 | Eight 10-bit symbol phases, lane k at bits [10k+9:10k] |
| gainShift | input | 4 | Loop gain as a right shift of the scaled error sum |
| outValid | output | 1 | Rotated block present |
| outPh | output | 80 | Eight rotated phases, same lane layout as `inPh` |
| freqEst | output | 18 | Current signed frequency estimate, 10 fractional bits |

## Verification
The assertions take for granted that `inValid` is a clean level, sampled only at the clock edge. They also assume `gainShift` is steady around each update, though nothing breaks if it changes.

The holding and latency properties require no particular phase content. The stimulus therefore mixes idle cycles into every sequence, from random gaps and from directed idle pairs. Phase content stays inside the capture range in the tracking runs and is fully random in the stress run, where only the bench's reference model judges correctness.

// File: rtl/pft_pkg.sv
package pft_pkg;

  localparam int DEF_LANES = 8;
  localparam int DEF_PW    = 10;
  localparam int DEF_FRAC  = 10;
  localparam int DEF_GW    = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // accept a block, advance the ramp base
    logic update;    // output block valid, update frequency
    logic lane0En;   // a previous block exists for lane-0 difference
  } pftStrobe_t;

endpackage

// File: rtl/pft_ctrl.sv
module pft_ctrl
  import pft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       outValid,
  output pftStrobe_t strb
);

  logic validR;
  logic havePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validR   <= 1'b0;
      havePrev <= 1'b0;
    end else begin
      validR   <= inValid;
      if (validR) havePrev <= 1'b1;
    end
  end

  always_comb begin
    strb.advance = inValid;
    strb.update  = validR;
    strb.lane0En = havePrev;
  end

  assign outValid = validR;

endmodule

// File: rtl/pft_datapath.sv
module pft_datapath
  import pft_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int PW    = DEF_PW,
  parameter int FRAC  = DEF_FRAC,
  parameter int GW    = DEF_GW
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  pftStrobe_t                   strb,
  input  logic [LANES*PW-1:0]          inPh,
  input  logic [GW-1:0]                gainShift,
  output logic [LANES*PW-1:0]          outPh,
  output logic signed [PW-2+FRAC-1:0]  freqEst
);

  localparam int FW = PW - 2 + FRAC;         // frequency width, +/- 1/8 turn
  localparam int AW = PW + FRAC;             // ramp accumulator width
  localparam int LW = $clog2(LANES);
  localparam int SW = PW + LW;               // lane error sum width
  localparam int DW = SW + FRAC;             // scaled sum width
  localparam logic signed [DW:0] FMAX = (DW+1)'((longint'(1) << (FW-1)) - 1);
  localparam logic signed [DW:0] FMIN = -(DW+1)'(longint'(1) << (FW-1));

  // constant scaling by shift-and-add only
  function automatic logic [AW-1:0] scaleConst(input logic [AW-1:0] v, input int k);
    logic [AW-1:0] acc;
    acc = '0;
    for (int b = 0; b < 16; b++) begin
      if (k[b]) acc = acc + (v << b);
    end
    return acc;
  endfunction

  // rotate one phase by the top bits of a ramp value
  function automatic logic [PW-1:0] rotatePh(input logic [PW-1:0] ph,
                                             input logic [AW-1:0] ramp);
    logic [AW-1:0] sh;
    sh = ramp >> FRAC;
    return ph - sh[PW-1:0];
  endfunction

  // pre-decision differential error: 4*(cur-prev) mod turn, signed
  function automatic logic signed [PW-1:0] diffErr(input logic [PW-1:0] cur,
                                                   input logic [PW-1:0] prv,
                                                   input logic          en);
    logic [PW-1:0] d;
    logic [PW-1:0] q;
    d = cur - prv;
    q = {d[PW-3:0], 2'b00};
    return en ? $signed(q) : '0;
  endfunction

  logic [AW-1:0]           baseAcc;
  logic signed [FW-1:0]    freqAcc;
  logic [AW-1:0]           freqExt;
  logic [PW-1:0]           rotReg  [LANES];
  logic [PW-1:0]           rotNext [LANES];
  logic signed [PW-1:0]    laneErr [LANES];
  logic [PW-1:0]           prevLast;
  logic signed [SW-1:0]    errSum;
  logic signed [DW-1:0]    deltaV;
  logic signed [DW:0]      sumWide;
  logic signed [FW-1:0]    freqNext;

  assign freqExt = {{(AW-FW){freqAcc[FW-1]}}, freqAcc};

  // per-lane rotation and error
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rotNext[k] = rotatePh(inPh[k*PW +: PW], baseAcc + scaleConst(freqExt, k));
    if (k == 0) begin : g_first
      assign laneErr[k] = diffErr(rotReg[0], prevLast, strb.lane0En);
    end else begin : g_rest
      assign laneErr[k] = diffErr(rotReg[k], rotReg[k-1], 1'b1);
    end
    assign outPh[k*PW +: PW] = rotReg[k];
  end

  always_comb begin
    errSum = '0;
    for (int k = 0; k < LANES; k++) begin
      errSum = errSum + SW'(laneErr[k]);
    end
  end

  assign deltaV  = $signed({errSum, {FRAC{1'b0}}}) >>> gainShift;
  assign sumWide = (DW+1)'(freqAcc) + (DW+1)'(deltaV);

  always_comb begin
    if (sumWide > FMAX)      freqNext = FMAX[FW-1:0];
    else if (sumWide < FMIN) freqNext = FMIN[FW-1:0];
    else                     freqNext = sumWide[FW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAcc  <= '0;
      freqAcc  <= '0;
      prevLast <= '0;
      for (int k = 0; k < LANES; k++) rotReg[k] <= '0;
    end else begin
      if (strb.advance) begin
        baseAcc <= baseAcc + scaleConst(freqExt, LANES);
        for (int k = 0; k < LANES; k++) rotReg[k] <= rotNext[k];
      end
      if (strb.update) begin
        freqAcc  <= freqNext;
        prevLast <= rotReg[LANES-1];
      end
    end
  end

  assign freqEst = freqAcc;

endmodule

// File: rtl/phase_freq_tracker.sv
module phase_freq_tracker
  import pft_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int PW    = DEF_PW,
  parameter int FRAC  = DEF_FRAC,
  parameter int GW    = DEF_GW
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [LANES*PW-1:0]          inPh,
  input  logic [GW-1:0]                gainShift,
  output logic                         outValid,
  output logic [LANES*PW-1:0]          outPh,
  output logic signed [PW-2+FRAC-1:0]  freqEst
);

  pftStrobe_t strb;

  pft_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outValid (outValid),
    .strb     (strb)
  );

  pft_datapath #(
    .LANES (LANES),
    .PW    (PW),
    .FRAC  (FRAC),
    .GW    (GW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inPh      (inPh),
    .gainShift (gainShift),
    .outPh     (outPh),
    .freqEst   (freqEst)
  );

endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
  parameter int PHW = 80,
  parameter int FW  = 18
)(
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  outValid,
  input logic [PHW-1:0]        outPh,
  input logic signed [FW-1:0]  freqEst
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outPh));

  // R8
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |=> $stable(freqEst));

endmodule

bind phase_freq_tracker pft_checker #(
  .PHW (LANES*PW),
  .FW  (PW-2+FRAC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outPh    (outPh),
  .freqEst  (freqEst)
);

// File: tb/sim_phase_freq_tracker.sv
module sim_phase_freq_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int NL   = 8;
  localparam int PW   = 10;
  localparam int FW   = 18;
  localparam int PMSK = 1023;
  localparam int BMSK = (1 << 20) - 1;
  localparam int FMAX = 131071;
  localparam int FMIN = -131072;

  logic                 clk = 0;
  logic                 rstN = 0;
  logic                 inValid = 0;
  logic [NL*PW-1:0]     inPh = '0;
  logic [3:0]           gainShift = 4'd7;
  logic                 outValid;
  logic [NL*PW-1:0]     outPh;
  logic signed [FW-1:0] freqEst;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference state
  int mBase, mFreq, mPrev;
  int mOut[NL];
  bit mHave, mOutValid;
  int symIdx;

  phase_freq_tracker u0 (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inPh      (inPh),
    .gainShift (gainShift),
    .outValid  (outValid),
    .outPh     (outPh),
    .freqEst   (freqEst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  function automatic int laneE(int cur, int prv);
    int d, q;
    d = (cur - prv) & PMSK;
    q = (d * 4) & PMSK;
    return (q >= 512) ? q - 1024 : q;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    inValid = 0;
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 0 && freqEst == 0 && outPh == '0, "R1", "reset state freq",
          freqEst, 0);
    rstN = 1;
    mBase = 0; mFreq = 0; mPrev = 0; mHave = 0; mOutValid = 0; symIdx = 0;
    for (int k = 0; k < NL; k++) mOut[k] = 0;
    @(posedge clk); #1;
    check(outValid == 0 && freqEst == 0 && outPh == '0, "R1", "after release freq",
          freqEst, 0);
  endtask

  // one clock: drive, predict, compare
  task automatic step(bit v, int ph[NL]);
    int nOut[NL];
    int nFreq, nBase, nPrev, sum, delta, w;
    bit nHave;
    bit ok;
    inValid = v;
    for (int k = 0; k < NL; k++) inPh[k*PW +: PW] = ph[k][PW-1:0];
    nOut = mOut; nFreq = mFreq; nBase = mBase; nPrev = mPrev; nHave = mHave;
    if (v) begin
      for (int k = 0; k < NL; k++) begin
        w = ((mBase + k * mFreq) & BMSK) >> 10;
        nOut[k] = (ph[k] - w) & PMSK;
      end
      nBase = (mBase + 8 * mFreq) & BMSK;
    end
    if (mOutValid) begin
      sum = mHave ? laneE(mOut[0], mPrev) : 0;
      for (int k = 1; k < NL; k++) sum += laneE(mOut[k], mOut[k-1]);
      delta = (sum * 1024) >>> gainShift;
      nFreq = mFreq + delta;
      if (nFreq > FMAX) nFreq = FMAX;
      if (nFreq < FMIN) nFreq = FMIN;
      nPrev = mOut[NL-1];
      nHave = 1;
    end
    @(posedge clk); #1;
    mOut = nOut; mFreq = nFreq; mBase = nBase; mPrev = nPrev; mHave = nHave;
    mOutValid = v;
    ok = (outValid == v) && (freqEst == mFreq);
    for (int k = 0; k < NL; k++) ok = ok && (int'(outPh[k*PW +: PW]) == mOut[k]);
    // R2 R3 R4 R5 R6 R7 R8 against the reference
    check(ok, "R2-model", "freqEst/lanes", freqEst, mFreq);
  endtask

  task automatic idle();
    int z[NL];
    for (int k = 0; k < NL; k++) z[k] = 0;
    step(0, z);
  endtask

  // QPSK symbols with constant offset (Q10 per symbol) and small noise
  task automatic offsetBlock(int offQ, int noise);
    int ph[NL];
    longint acc;
    for (int k = 0; k < NL; k++) begin
      acc = (longint'(symIdx) * offQ) >>> 10;
      ph[k] = (int'($urandom_range(0, 3)) * 256 + int'(acc)
               + int'($urandom_range(0, 2*noise)) - noise) & PMSK;
      symIdx++;
    end
    step(1, ph);
  endtask

  task automatic rampBlock(int stepPh);
    int ph[NL];
    for (int k = 0; k < NL; k++) begin
      ph[k] = (symIdx * stepPh) & PMSK;
      symIdx++;
    end
    step(1, ph);
  endtask

  initial begin
    int hold;
    logic [NL*PW-1:0] outSave;
    int rnd[NL];
    void'($urandom(32'd1234));

    // R1 reset state
    doReset();

    // R9 positive offset tracking with random idle gaps (R3, R8)
    gainShift = 4'd7;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle();
      else offsetBlock(41472, 3);
    end
    idle(); idle();
    check((freqEst > 41472 - 3072) && (freqEst < 41472 + 3072), "R9",
          "positive offset settle", freqEst, 41472);

    // R8 explicit hold across idle cycles
    hold = freqEst;
    outSave = outPh;
    idle(); idle();
    check(freqEst == hold, "R8", "freq held while idle", freqEst, hold);
    check(outPh == outSave, "R8", "phases held while idle", outPh[9:0], outSave[9:0]);

    // R9 negative offset near capture edge
    doReset();
    gainShift = 4'd6;
    for (int i = 0; i < 400; i++) offsetBlock(-102400, 2);
    idle(); idle();
    check((freqEst > -102400 - 3072) && (freqEst < -102400 + 3072), "R9",
          "negative offset settle", freqEst, -102400);

    // R7 positive saturation; R5 first-block lane-0 exclusion in the sum
    doReset();
    gainShift = 4'd0;
    rampBlock(120);
    idle();
    check(freqEst == FMAX, "R7", "positive saturation", freqEst, FMAX);

    // R7 negative saturation
    doReset();
    gainShift = 4'd0;
    rampBlock(-120);
    idle();
    check(freqEst == FMIN, "R7", "negative saturation", freqEst, FMIN);

    // R5: first block, lane 0 excluded; 8 lanes of step 4 -> 7 errors of 16
    doReset();
    gainShift = 4'd10;
    rampBlock(4);
    idle();
    check(freqEst == 7 * 16, "R5", "lane-0 excluded first block", freqEst, 112);
    // R4: second block includes lane 0 -> 8 errors of 16 more
    rampBlock(4);
    idle();
    check(freqEst == 112 + 128, "R4", "lane-0 uses previous lane 7", freqEst, 240);

    // R2 R3 R6 random stress with random gain and gaps
    doReset();
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 7) == 0) gainShift = 4'($urandom_range(0, 12));
      for (int k = 0; k < NL; k++) rnd[k] = int'($urandom_range(0, PMSK));
      step($urandom_range(0, 4) != 0, rnd);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule